// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block is a watchdog timer for a small microcontroller core. It counts ticks from one of three selectable sources: the system clock divided by four, a slow real-time oscillator, or a dedicated watchdog oscillator. If software lets too much time pass without a clear, the block issues a one-cycle reset request. Every oscillator tick is brought into the system clock domain as a single-cycle enable, so all counting logic runs on one clock.

Static option inputs set its behaviour. One enables the timer, one picks the tick source, one picks one of four time-out ranges, and one picks the clear discipline. In single mode, one clear strobe from the instruction decoder restarts the time-out. In paired mode, two different strobes must both be seen, in either order, before the count restarts. The options are captured only while the global reset is asserted. The time-out is a one-octave window, not an exact count. A free-running prescaler that no clear can touch feeds a one-bit stage, and only that stage is reset by a clear.

Top module: `wdt_core`

## Requirements
- R1: With the enable option captured as 0, `wdt_rst` stays low for as long as reset is released.
- R2: Source code 0 counts one tick every 4 system clocks. Code 1 counts rising edges of `rtc_osc`. Codes 2 and 3 count rising edges of `wosc_osc`. Edges on an unselected oscillator have no effect.
- R3: With range code r (0 to 3) and `BASE_EXP` = B (default 12), `wdt_rst` pulses more than 2^(B+r) and at most 2^(B+r+1) ticks after the last clear or reset release.
- R4: In single mode (`cfg_pair` = 0), a `clr_single` strobe restarts the time-out window.
- R5: In paired mode (`cfg_pair` = 1), the time-out restarts only after both `clr_pair_a` and `clr_pair_b` have been seen since the last restart. They may come in either order or in the same cycle. Either one alone has no effect, and both pending flags clear when the restart happens.
- R6: In paired mode, `clr_single` is ignored. In single mode, `clr_pair_a` and `clr_pair_b` are ignored.
- R7: The time-out output is high for exactly one system clock. If no clear follows, it pulses again every 2^(B+r+1) ticks.
- R8: The option inputs are sampled only while `rst_n` is low. Changes to them after reset release have no effect.
- R9: A global reset (`rst_n` low) clears the stage, the prescaler, the tick logic and both paired-clear pending flags, and holds `wdt_rst` low.
- R10: Each selected oscillator rising edge produces exactly one single-cycle tick, after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global reset, active low, synchronous; options are sampled while it is low |
| cfg_en | input | 1 | Option: watchdog enable |
| cfg_src | input | 2 | Option: tick source (0 sys/4, 1 rtc, 2/3 watchdog oscillator) |
| cfg_range | input | 2 | Option: time-out range code |
| cfg_pair | input | 1 | Option: 0 single clear, 1 paired clear |
| rtc_osc | input | 1 | Real-time oscillator square wave, asynchronous |
| wosc_osc | input | 1 | Watchdog oscillator square wave, asynchronous |
| clr_single | input | 1 | Single-cycle plain clear strobe |
| clr_pair_a | input | 1 | Single-cycle first paired clear strobe |
| clr_pair_b | input | 1 | Single-cycle second paired clear strobe |
| wdt_rst | output | 1 | One-cycle time-out reset request |

## Verification
Some properties are checked by assertions on every cycle. These are: a disabled watchdog stays silent, the time-out pulse lasts one cycle, a clear drops the stage, ticks never come on back-to-back cycles, the two pending flags are never both held, single mode keeps no pending flags, and the captured options stay stable after reset. Other behaviour can only be shown by the bench's scenarios, which measure elapsed time. These are: the time-out landing inside its octave window for each range and source, the either-order paired clear, the strobes that are ignored in each mode, and pending flags that do not survive a global reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SRC_SYS4  = 2'd0,
    SRC_RTC   = 2'd1,
    SRC_WOSC  = 2'd2,
    SRC_WOSC2 = 2'd3
  } wdt_src_e;

  typedef struct packed {
    logic      en;
    wdt_src_e  src;
    logic [1:0] range;
    logic      pair;
  } wdt_cfg_t;

  // Exponent of the prescaler wrap for a given range code.
  function automatic int unsigned wrap_exp(input int unsigned base, input logic [1:0] rng);
    return base + int'(rng);
  endfunction

  // Low-bits mask whose all-ones pattern marks a prescaler wrap.
  function automatic logic [31:0] wrap_mask(input int unsigned e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYS_DIV     = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  wdt_src_e src,
  input  logic     rtc_osc,
  input  logic     wosc_osc,
  output logic     tick
);
  localparam int unsigned DW   = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int unsigned NOSC = 2;

  logic [NOSC-1:0] osc_raw;
  logic [NOSC-1:0] osc_edge;
  logic [DW-1:0]   divc;
  logic            sys_tick;

  assign osc_raw = {wosc_osc, rtc_osc};

  // One synchroniser plus rising-edge detector per oscillator (R10).
  for (genvar g = 0; g < NOSC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh;
    logic                   last;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh   <= '0;
        last <= 1'b0;
      end else begin
        sh   <= {sh[SYNC_STAGES-2:0], osc_raw[g]};
        last <= sh[SYNC_STAGES-1];
      end
    end
    assign osc_edge[g] = sh[SYNC_STAGES-1] & ~last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   divc <= '0;
    else if (run) divc <= (divc == DW'(SYS_DIV - 1)) ? '0 : divc + 1'b1;
  end
  assign sys_tick = run && (divc == DW'(SYS_DIV - 1));

  always_comb begin
    unique case (src)
      SRC_SYS4: tick = sys_tick;
      SRC_RTC:  tick = run && osc_edge[0];
      default:  tick = run && osc_edge[1];
    endcase
  end

  // R10: a tick never lasts longer than one cycle.
  a_r10_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_mode,
  input  logic clr_single,
  input  logic clr_pair_a,
  input  logic clr_pair_b,
  output logic clr_now,
  output logic pend_a,
  output logic pend_b
);
  logic seen_a, seen_b, both;

  assign seen_a = pend_a | clr_pair_a;
  assign seen_b = pend_b | clr_pair_b;
  assign both   = seen_a & seen_b;

  // R4/R5/R6: the strobes that count depend on the captured mode.
  assign clr_now = pair_mode ? both : clr_single;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else if (!pair_mode || both) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      pend_a <= seen_a;
      pend_b <= seen_b;
    end
  end

  // R5: once both halves are seen, they are consumed at once.
  a_r5_flags_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_a && pend_b));

  // R6: single mode keeps no paired state.
  a_r6_no_flags_single: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |=> (!pend_a && !pend_b));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned NRANGE   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] range,
  input  logic       clr,
  output logic       stage,
  output logic       carry,
  output logic       timeout
);
  localparam int unsigned PW = BASE_EXP + NRANGE - 1;

  logic [PW-1:0] pre;
  logic [PW-1:0] mask;
  logic          fire;

  assign mask  = PW'(wrap_mask(wrap_exp(BASE_EXP, range)));
  assign carry = tick && ((pre & mask) == mask);
  assign fire  = carry && stage && !clr;

  // Free-running prescaler; only a global reset clears it.
  always_ff @(posedge clk) begin
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= pre + 1'b1;
  end

  // One-bit stage: the only part a clear restarts (R3, R4).
  always_ff @(posedge clk) begin
    if (!rst_n)     stage <= 1'b0;
    else if (clr)   stage <= 1'b0;
    else if (carry) stage <= ~stage;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) timeout <= 1'b0;
    else        timeout <= fire;
  end

  // R4: a clear always leaves the stage empty.
  a_r4_clear_drops_stage: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !stage);

  // R7: the time-out request is one cycle wide.
  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R3: a time-out is only ever the second wrap after a restart.
  a_r3_needs_stage: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !stage);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP    = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYS_DIV     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic [1:0] cfg_src,
  input  logic [1:0] cfg_range,
  input  logic       cfg_pair,
  input  logic       rtc_osc,
  input  logic       wosc_osc,
  input  logic       clr_single,
  input  logic       clr_pair_a,
  input  logic       clr_pair_b,
  output logic       wdt_rst
);
  wdt_cfg_t cfg_q;
  logic     tick, clr_now, pend_a, pend_b, stage, carry, timeout;

  // R8: options are captured only while the global reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '{en: cfg_en, src: wdt_src_e'(cfg_src),
                           range: cfg_range, pair: cfg_pair};
  end

  wdt_tick_sel #(.SYNC_STAGES(SYNC_STAGES), .SYS_DIV(SYS_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.en), .src(cfg_q.src),
    .rtc_osc(rtc_osc), .wosc_osc(wosc_osc), .tick(tick)
  );

  wdt_clear_ctl u_clr (
    .clk(clk), .rst_n(rst_n), .pair_mode(cfg_q.pair),
    .clr_single(clr_single), .clr_pair_a(clr_pair_a), .clr_pair_b(clr_pair_b),
    .clr_now(clr_now), .pend_a(pend_a), .pend_b(pend_b)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .range(cfg_q.range),
    .clr(clr_now), .stage(stage), .carry(carry), .timeout(timeout)
  );

  assign wdt_rst = timeout;

  // R1: a disabled watchdog never requests reset.
  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> !wdt_rst);

  // R8: captured options hold still while running.
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg_q));

  // R1: no wrap activity at all without enable.
  a_r1_no_carry_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> !carry);

endmodule

// File: tb/tb_wdt_core.sv
`timescale 1ns/1ps
module tb_wdt_core;
  localparam int B = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1, cfg_pair = 1'b0;
  logic [1:0] cfg_src = 2'd0, cfg_range = 2'd0;
  logic rtc_osc = 1'b0, wosc_osc = 1'b0;
  logic clr_single = 1'b0, clr_pair_a = 1'b0, clr_pair_b = 1'b0;
  logic wdt_rst;

  int n_run = 0, n_fail = 0;
  int rtc_half = 0, wosc_half = 0, rtc_cnt = 0, wosc_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_core #(.BASE_EXP(B)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .cfg_range(cfg_range), .cfg_pair(cfg_pair), .rtc_osc(rtc_osc),
    .wosc_osc(wosc_osc), .clr_single(clr_single), .clr_pair_a(clr_pair_a),
    .clr_pair_b(clr_pair_b), .wdt_rst(wdt_rst)
  );

  always @(negedge clk) begin
    if (rtc_half > 0) begin
      rtc_cnt++;
      if (rtc_cnt >= rtc_half) begin rtc_cnt = 0; rtc_osc <= ~rtc_osc; end
    end
    if (wosc_half > 0) begin
      wosc_cnt++;
      if (wosc_cnt >= wosc_half) begin wosc_cnt = 0; wosc_osc <= ~wosc_osc; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input bit en, input logic [1:0] src, input logic [1:0] rng, input bit pair);
    @(negedge clk);
    cfg_en = en; cfg_src = src; cfg_range = rng; cfg_pair = pair;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // which: 0 single, 1 pair a, 2 pair b, 3 both pairs together
  task automatic strobe(input int which);
    @(negedge clk);
    clr_single = (which == 0);
    clr_pair_a = (which == 1) || (which == 3);
    clr_pair_b = (which == 2) || (which == 3);
    @(negedge clk);
    clr_single = 0; clr_pair_a = 0; clr_pair_b = 0;
  endtask

  // Cycles until wdt_rst is seen high; -1 if none within maxc.
  task automatic wait_pulse(input int maxc, output int cyc);
    cyc = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (wdt_rst) begin cyc = i; break; end
    end
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst) seen = 1;
    end
  endtask

  function automatic int lo_cyc(input int r, input int per);
    return (1 << (B + r)) * per - per;
  endfunction
  function automatic int hi_cyc(input int r, input int per);
    return (1 << (B + r + 1)) * per + 4 * per;
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0; cfg_en = 1; cfg_src = 0; cfg_range = 0; cfg_pair = 0;
    repeat (3) @(negedge clk);
    check(wdt_rst == 1'b0, "R9 reset holds wdt_rst low", wdt_rst, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_window(input int r);
    int c, c2;
    do_reset(1, 2'd0, 2'(r), 0);
    wait_pulse(hi_cyc(r, 4) + 10, c);
    check(c >= lo_cyc(r, 4) && c <= hi_cyc(r, 4), $sformatf("R3 window range %0d", r), c, hi_cyc(r, 4));
    @(negedge clk);
    check(wdt_rst == 1'b0, "R7 pulse one cycle", wdt_rst, 0);
    wait_pulse(hi_cyc(r, 4) + 10, c2);
    c2 = c2 + 1;
    check(c2 == (1 << (B + r + 1)) * 4, "R7 repeat period", c2, (1 << (B + r + 1)) * 4);
  endtask

  task automatic t_single_clear();
    bit seen; int c;
    do_reset(1, 2'd0, 2'd0, 0);
    for (int k = 0; k < 15; k++) begin
      strobe(0);
      quiet(40, seen);
      if (seen) break;
    end
    check(!seen, "R4 single clears keep watchdog quiet", seen, 0);
    strobe(0);
    wait_pulse(hi_cyc(0, 4) + 10, c);
    check(c >= lo_cyc(0, 4) && c <= hi_cyc(0, 4), "R4 time-out after last clear", c, hi_cyc(0, 4));
  endtask

  task automatic t_pair_order(input int mode);
    bit seen; int c;
    do_reset(1, 2'd0, 2'd0, 1);
    for (int k = 0; k < 15; k++) begin
      if (mode == 0) begin strobe(1); strobe(2); end
      else if (mode == 1) begin strobe(2); repeat (3) @(negedge clk); strobe(1); end
      else strobe(3);
      quiet(36, seen);
      if (seen) break;
    end
    check(!seen, $sformatf("R5 paired clears order %0d keep quiet", mode), seen, 0);
    wait_pulse(hi_cyc(0, 4) + 10, c);
    check(c > 0, "R5 time-out once clears stop", c, 1);
  endtask

  task automatic t_pair_half(input int which);
    int c, el; bit seen;
    do_reset(1, 2'd0, 2'd0, 1);
    el = 0; c = -1;
    for (int k = 0; k < 10 && c < 0; k++) begin
      strobe(which); strobe(0); el += 4;
      wait_pulse(16, c);
      if (c > 0) el += c; else el += 16;
    end
    check(c > 0 && el <= hi_cyc(0, 4) + 4, $sformatf("R5 R6 strobe %0d alone does not clear", which), el, hi_cyc(0, 4));
    quiet(1, seen);
  endtask

  task automatic t_single_ignores_pairs();
    int c, el;
    do_reset(1, 2'd0, 2'd0, 0);
    el = 0; c = -1;
    for (int k = 0; k < 10 && c < 0; k++) begin
      strobe(3); strobe(1); strobe(2); el += 6;
      wait_pulse(16, c);
      if (c > 0) el += c; else el += 16;
    end
    check(c > 0 && el <= hi_cyc(0, 4) + 4, "R6 paired strobes ignored in single mode", el, hi_cyc(0, 4));
  endtask

  task automatic t_disabled();
    bit seen;
    do_reset(0, 2'd0, 2'd0, 0);
    quiet(3000, seen);
    check(!seen, "R1 disabled never resets", seen, 0);
  endtask

  task automatic t_osc(input int which);
    int c;
    rtc_half = 0; wosc_half = 0;
    if (which == 1) rtc_half = 4; else wosc_half = 8;
    do_reset(1, 2'(which), 2'd0, 0);
    wait_pulse(hi_cyc(0, which == 1 ? 8 : 16) + 20, c);
    check(c >= lo_cyc(0, which == 1 ? 8 : 16) && c <= hi_cyc(0, which == 1 ? 8 : 16),
          $sformatf("R2 R10 oscillator source %0d timing", which), c, hi_cyc(0, which == 1 ? 8 : 16));
    rtc_half = 0; wosc_half = 0;
  endtask

  task automatic t_unselected_osc();
    bit seen;
    rtc_half = 0; wosc_half = 2;
    do_reset(1, 2'd1, 2'd0, 0);
    quiet(1500, seen);
    check(!seen, "R2 unselected oscillator edges ignored", seen, 0);
    wosc_half = 0;
  endtask

  task automatic t_cfg_held();
    int c;
    do_reset(1, 2'd0, 2'd0, 0);
    @(negedge clk);
    cfg_range = 2'd3; cfg_en = 0; cfg_pair = 1;
    wait_pulse(hi_cyc(0, 4) + 10, c);
    check(c > 0 && c <= hi_cyc(0, 4), "R8 options after reset ignored", c, hi_cyc(0, 4));
  endtask

  task automatic t_reset_flags();
    int c, el;
    do_reset(1, 2'd0, 2'd0, 1);
    strobe(1);
    do_reset(1, 2'd0, 2'd0, 1);
    el = 0; c = -1;
    for (int k = 0; k < 10 && c < 0; k++) begin
      strobe(2); el += 2;
      wait_pulse(18, c);
      if (c > 0) el += c; else el += 18;
    end
    check(c > 0 && el <= hi_cyc(0, 4) + 4, "R9 pending flag cleared by reset", el, hi_cyc(0, 4));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    for (int r = 0; r < 4; r++) t_window(r);
    t_single_clear();
    t_pair_order(0);
    t_pair_order(1);
    t_pair_order(2);
    t_pair_half(1);
    t_pair_half(2);
    t_single_ignores_pairs();
    t_disabled();
    t_osc(1);
    t_osc(2);
    t_unselected_osc();
    t_cfg_held();
    t_reset_flags();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule